// File: doc/BRIEF.md
# East-Bound Mesh Router Switch Allocator

This block assigns the four outgoing ports of the east-bound half of a 2-D mesh wormhole router to its four incoming ports. The incoming ports are the west link, the northern and southern east-bound vertical links, and the local injection port. The outgoing ports are the northern and southern east-bound vertical links, the east link and the local ejection port. Each input shows a valid flag, a 2-bit flit kind and a set of outputs its packet may legally take. The block then locks an output to one input for the whole packet.

Outputs are served one after another in a fixed order. For each output, the block takes the first eligible input in that output's own clockwise list. An input that wins an earlier output drops out of the later ones in the same round. A won output stays locked to its input until that input's tail flit leaves through it. The west-bound half uses a mirrored instance with its own lists.

Index map used throughout. Inputs: west = 0, north-1 = 1, south-1 = 2, local = 3. Outputs: north-1 = 0, east = 1, south-1 = 2, local = 3. Flit kinds: 00 idle, 01 head, 10 body, 11 tail. Input i carries its route set in `in_route[4i+3:4i]`, where bit o selects output o, and its kind in `in_kind[2i+1:2i]`. Bit `4o+i` of `out_grant` means output o is locked to input i.

Top module: `eb_switch_alloc`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_grant` is all zero.
- R2: In one round, outputs are served in the order 0, 1, 2, 3. An input that wins an output is not granted any later output in that round. An input whose route set names several outputs gets only the first of them that it wins.
- R3: Output 0 (north-1) takes inputs in the order south-1, west, local. It is never granted to input 1 (north-1).
- R4: Output 1 (east) takes inputs in the order south-1, west, north-1, local.
- R5: Output 2 (south-1) takes inputs in the order west, north-1, local. It is never granted to input 2 (south-1).
- R6: Output 3 (local) takes inputs in the order north-1, south-1, west. It is never granted to input 3 (local).
- R7: A new grant goes only to an input with valid high, kind head (01), and the output's bit set in its route set. Idle, body and tail flits never create a grant.
- R8: A free output is granted only in a cycle when its `out_rdy` bit is high.
- R9: A locked output stays with the same input, and is offered to no other input, until that input presents a valid tail flit (11) while `out_rdy` of that output is high.
- R10: That tail cycle clears the lock at the next clock edge. The output can be granted again only from the cycle after the lock has cleared.
- R11: An input that holds a lock is not considered for any other output, even if it presents a head flit. No input ever holds more than one output.
- R12: The new lock state appears on `out_grant` one clock edge after the cycle in which the inputs were presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 4 | Per-input flit valid |
| in_route | input | 16 | Per-input set of legal outputs, 4 bits per input |
| in_kind | input | 8 | Per-input flit kind, 2 bits per input |
| out_rdy | input | 4 | Per-output downstream buffer has room |
| out_grant | output | 16 | Registered lock matrix, bit 4o+i = output o held by input i |

## Verification
Directed cases fill each output's list with every eligible input, then remove the current winner one input at a time. This pins the exact rank order and shows that U-turn inputs are never granted. A single input whose route names several outputs, and two inputs that both want the same early output, separate correct exclusion from a design that grants an input twice or skips the losing input. Packet sequences then check lock holding: body flits, rival heads, a tail while ready is low, and a head from an input that already owns an output. They also check that an output freed by a tail is not given away in the same cycle. Random per-cycle valid, kind, route and ready values then mix all of these cases against a bench model of the lock matrix.

// File: rtl/eb_alloc_pkg.sv
package eb_alloc_pkg;

    localparam int N_IN   = 4;
    localparam int N_OUT  = 4;
    localparam int IDX_W  = $clog2(N_IN);
    localparam int KIND_W = 2;
    localparam int ORD_W  = N_IN * IDX_W;

    typedef enum logic [KIND_W-1:0] {
        FL_IDLE = 2'b00,
        FL_HEAD = 2'b01,
        FL_BODY = 2'b10,
        FL_TAIL = 2'b11
    } flit_kind_e;

    // Input ranking per output, slot k in bits [IDX_W*k +: IDX_W].
    // Inputs: W=0, N1=1, S1=2, INT=3.  Outputs: N1=0, E=1, S1=2, INT=3.
    localparam logic [N_OUT-1:0][ORD_W-1:0] PRIO_ORD = {
        8'h09,   // out INT: N1, S1, W
        8'h34,   // out S1 : W, N1, INT
        8'hD2,   // out E  : S1, W, N1, INT
        8'h32    // out N1 : S1, W, INT
    };

    function automatic int prio_len(input int o);
        return (o == 1) ? 4 : 3;
    endfunction

    typedef struct packed {
        logic [N_OUT-1:0]            vld;
        logic [N_OUT-1:0][IDX_W-1:0] idx;
    } lock_t;

endpackage

// File: rtl/eb_prio_pick.sv
module eb_prio_pick
    import eb_alloc_pkg::*;
#(
    parameter int                LEN   = 3,
    parameter logic [ORD_W-1:0]  ORDER = '0
) (
    input  logic [N_IN-1:0]  cand,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [N_IN-1:0]  sel
);

    always_comb begin
        hit = 1'b0;
        idx = '0;
        sel = '0;
        for (int k = 0; k < LEN; k++) begin
            if (!hit && cand[ORDER[IDX_W*k +: IDX_W]]) begin
                hit = 1'b1;
                idx = ORDER[IDX_W*k +: IDX_W];
                sel[ORDER[IDX_W*k +: IDX_W]] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/eb_switch_alloc.sv
module eb_switch_alloc
    import eb_alloc_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        in_vld,
    input  logic [N_IN*N_OUT-1:0]  in_route,
    input  logic [N_IN*KIND_W-1:0] in_kind,
    input  logic [N_OUT-1:0]       out_rdy,
    output logic [N_OUT*N_IN-1:0]  out_grant
);

    lock_t lock_q, lock_d;

    logic [N_IN-1:0]  busy;
    logic [N_IN-1:0]  head_ok;
    logic [N_IN-1:0]  tail_ok;
    logic [N_OUT-1:0] own_col [N_IN];
    logic [N_IN-1:0]  taken [N_OUT+1];
    logic [N_IN-1:0]  cand  [N_OUT];
    logic [N_IN-1:0]  sel   [N_OUT];
    logic [N_OUT-1:0] hit;
    logic [IDX_W-1:0] pick  [N_OUT];

    // input qualifiers and ownership view
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            head_ok[i] = in_vld[i] && (in_kind[KIND_W*i +: KIND_W] == FL_HEAD);
            tail_ok[i] = in_vld[i] && (in_kind[KIND_W*i +: KIND_W] == FL_TAIL);
            for (int o = 0; o < N_OUT; o++) begin
                own_col[i][o] = lock_q.vld[o] && (lock_q.idx[o] == IDX_W'(i));
            end
            busy[i] = |own_col[i];
        end
    end

    assign taken[0] = '0;

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        always_comb begin
            for (int i = 0; i < N_IN; i++) begin
                cand[o][i] = head_ok[i] && in_route[N_OUT*i + o] && !busy[i]
                             && !taken[o][i] && out_rdy[o] && !lock_q.vld[o];
            end
        end

        eb_prio_pick #(
            .LEN   (prio_len(o)),
            .ORDER (PRIO_ORD[o])
        ) pick_i (
            .cand (cand[o]),
            .hit  (hit[o]),
            .idx  (pick[o]),
            .sel  (sel[o])
        );

        assign taken[o+1] = taken[o] | sel[o];

        AST_HOLD_UNTIL_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q.vld[o] && !(tail_ok[lock_q.idx[o]] && out_rdy[o]))
            |=> (lock_q.vld[o] && $stable(lock_q.idx[o]))); // R9

        AST_RELEASE_ON_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q.vld[o] && tail_ok[lock_q.idx[o]] && out_rdy[o])
            |=> !lock_q.vld[o]); // R10

        AST_GRANT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lock_q.vld[o]) |-> $past(out_rdy[o])); // R8
    end

    // next lock state
    always_comb begin
        lock_d = lock_q;
        for (int o = 0; o < N_OUT; o++) begin
            if (lock_q.vld[o]) begin
                if (tail_ok[lock_q.idx[o]] && out_rdy[o]) begin
                    lock_d.vld[o] = 1'b0;
                end
            end else if (hit[o]) begin
                lock_d.vld[o] = 1'b1;
                lock_d.idx[o] = pick[o];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            for (int i = 0; i < N_IN; i++) begin
                out_grant[N_IN*o + i] = own_col[i][o];
            end
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        AST_ONE_OUTPUT_PER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_col[i])); // R11
    end

    AST_NO_UTURN_N1: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q.vld[0] |-> (lock_q.idx[0] != IDX_W'(1))); // R3

    AST_NO_UTURN_S1: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q.vld[2] |-> (lock_q.idx[2] != IDX_W'(2))); // R5

    AST_NO_UTURN_INT: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q.vld[3] |-> (lock_q.idx[3] != IDX_W'(3))); // R6

endmodule

// File: tb/eb_switch_alloc_tb_top.sv
module eb_switch_alloc_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;
    localparam int N_RAND     = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  in_vld = '0;
    logic [15:0] in_route = '0;
    logic [7:0]  in_kind = '0;
    logic [3:0]  out_rdy = '0;
    logic [15:0] out_grant;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_g = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eb_switch_alloc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (in_vld),
        .in_route  (in_route),
        .in_kind   (in_kind),
        .out_rdy   (out_rdy),
        .out_grant (out_grant)
    );

    // ranking lists taken from R3..R6; 4 = empty slot
    function automatic int ord(input int o, input int k);
        case (o)
            0: case (k) 0: return 2; 1: return 0; 2: return 3; default: return 4; endcase
            1: case (k) 0: return 2; 1: return 0; 2: return 1; 3: return 3; default: return 4; endcase
            2: case (k) 0: return 0; 1: return 1; 2: return 3; default: return 4; endcase
            default: case (k) 0: return 1; 1: return 2; 2: return 0; default: return 4; endcase
        endcase
    endfunction

    function automatic logic [15:0] model_next(input logic [15:0] g, input logic [3:0] v,
                                               input logic [15:0] rt, input logic [7:0] kd,
                                               input logic [3:0] rdy);
        logic [15:0] n = g;
        logic [3:0]  busy = '0;
        logic [3:0]  tk = '0;
        for (int i = 0; i < 4; i++)
            for (int o = 0; o < 4; o++) if (g[4*o+i]) busy[i] = 1'b1;
        for (int o = 0; o < 4; o++) begin
            if (|g[4*o +: 4]) begin
                for (int i = 0; i < 4; i++)
                    if (g[4*o+i] && v[i] && kd[2*i +: 2] == 2'b11 && rdy[o]) n[4*o+i] = 1'b0;
            end else begin
                bit done = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    int i = ord(o, k);
                    if (!done && i < 4) begin
                        if (v[i] && kd[2*i +: 2] == 2'b01 && rt[4*i+o] && !busy[i]
                            && !tk[i] && rdy[o]) begin
                            n[4*o+i] = 1'b1;
                            tk[i]    = 1'b1;
                            done     = 1'b1;
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s out_grant actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge with outputs settled
    task automatic cyc(input logic [3:0] v, input logic [15:0] rt,
                       input logic [7:0] kd, input logic [3:0] rdy);
        in_vld = v; in_route = rt; in_kind = kd; out_rdy = rdy;
        exp_g = model_next(exp_g, v, rt, kd, rdy);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_vld = '0; in_route = '0; in_kind = '0; out_rdy = '0;
        exp_g = '0;
        @(negedge clk);
        chk("R1", out_grant, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        do_reset();
        cyc(4'h0, 16'h0, 8'h00, 4'hF);
        chk("R1", out_grant, 16'h0000);

        // R2 / R12: multi-route head gets only the first output, one edge later
        in_vld = 4'h1; in_route = 16'h0007; in_kind = 8'h01; out_rdy = 4'hF;
        exp_g = model_next(exp_g, in_vld, in_route, in_kind, out_rdy);
        @(posedge clk); #1;
        chk("R12", out_grant, 16'h0001);
        @(negedge clk);
        chk("R2", out_grant, 16'h0001);

        // R3 ranking of north-1 output
        do_reset(); cyc(4'hF, 16'h1111, 8'h55, 4'hF); chk("R3", out_grant, 16'h0004);
        do_reset(); cyc(4'h9, 16'h1001, 8'h55, 4'hF); chk("R3", out_grant, 16'h0001);
        do_reset(); cyc(4'hA, 16'h1010, 8'h55, 4'hF); chk("R3", out_grant, 16'h0008);
        do_reset(); cyc(4'h2, 16'h0010, 8'h55, 4'hF); chk("R3", out_grant, 16'h0000);

        // R4 ranking of east output
        do_reset(); cyc(4'hF, 16'h2222, 8'h55, 4'hF); chk("R4", out_grant, 16'h0040);
        do_reset(); cyc(4'hB, 16'h2022, 8'h55, 4'hF); chk("R4", out_grant, 16'h0010);
        do_reset(); cyc(4'hA, 16'h2020, 8'h55, 4'hF); chk("R4", out_grant, 16'h0020);

        // R5 ranking of south-1 output
        do_reset(); cyc(4'hE, 16'h4440, 8'h55, 4'hF); chk("R5", out_grant, 16'h0200);
        do_reset(); cyc(4'hC, 16'h4400, 8'h55, 4'hF); chk("R5", out_grant, 16'h0800);
        do_reset(); cyc(4'h4, 16'h0400, 8'h55, 4'hF); chk("R5", out_grant, 16'h0000);

        // R6 ranking of local output
        do_reset(); cyc(4'hF, 16'h8888, 8'h55, 4'hF); chk("R6", out_grant, 16'h2000);
        do_reset(); cyc(4'hD, 16'h8808, 8'h55, 4'hF); chk("R6", out_grant, 16'h4000);
        do_reset(); cyc(4'h8, 16'h8000, 8'h55, 4'hF); chk("R6", out_grant, 16'h0000);

        // R2 exclusion: S1 wins north-1, W falls to east
        do_reset(); cyc(4'h5, 16'h0302, 8'h11, 4'hF); chk("R2", out_grant, 16'h0014);

        // R7 non-head or invalid flits
        do_reset();
        cyc(4'h1, 16'h0001, 8'h02, 4'hF); chk("R7", out_grant, 16'h0000);
        cyc(4'h1, 16'h0001, 8'h03, 4'hF); chk("R7", out_grant, 16'h0000);
        cyc(4'h0, 16'h0001, 8'h01, 4'hF); chk("R7", out_grant, 16'h0000);
        cyc(4'h1, 16'h0002, 8'h01, 4'hE); chk("R7", out_grant, 16'h0010);

        // R8 ready gating, then R9/R11/R10 on the held lock
        do_reset();
        cyc(4'h1, 16'h0001, 8'h01, 4'hE); chk("R8", out_grant, 16'h0000);
        cyc(4'h1, 16'h0001, 8'h01, 4'hF); chk("R8", out_grant, 16'h0001);
        cyc(4'h5, 16'h0101, 8'h12, 4'hF); chk("R9", out_grant, 16'h0001);
        cyc(4'h1, 16'h0001, 8'h03, 4'hE); chk("R9", out_grant, 16'h0001);
        cyc(4'h1, 16'h0002, 8'h01, 4'hF); chk("R11", out_grant, 16'h0001);
        cyc(4'h5, 16'h0101, 8'h13, 4'hF); chk("R10", out_grant, 16'h0000);
        cyc(4'h4, 16'h0100, 8'h10, 4'hF); chk("R10", out_grant, 16'h0004);

        // random mix against the bench model
        do_reset();
        for (int n = 0; n < N_RAND; n++) begin
            logic [3:0] v, r;
            logic [15:0] rt;
            logic [7:0] kd;
            v = '0; r = '0;
            for (int i = 0; i < 4; i++) begin
                v[i] = ($urandom % 4) != 0;
                r[i] = ($urandom % 5) != 0;
            end
            rt = 16'($urandom);
            kd = 8'($urandom);
            cyc(v, rt, kd, r);
            chk("R2", out_grant, exp_g);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule